// File: doc/BRIEF.md
# Double-Buffered Pixel Scan Controller

The controller walks a 320 x 240 frame of 16-bit pixels in raster order and fetches each one from a memory-mapped frame store. It sends the fetched pixels to a downstream video stage as a valid/ready stream and marks the first pixel of every frame. It runs frame after frame without stopping. The pixel memory may be rewritten at any moment, so a pixel that has not been fetched yet shows its new value in the current frame. Pixels are 5:6:5 RGB (red in bits 15..11, green in 10..5, blue in 4..0). The controller passes them through without looking at them.

Each fetch address is the front base plus a packed offset. The line number y sits at byte-address bit 10 and up, the column x sits at bit 1 and up, and bit 0 is zero. Two base registers support double buffering. The front base is the frame being shown and the back base is the frame software draws into. A swap request is held pending until the frame in flight has issued its last fetch, and then the two bases trade places. Reads are prefetched against a small response buffer under a credit scheme. Back-pressure on the pixel stream therefore stops address generation without losing or repeating a pixel.

Top module: `pix_scan_ctrl`

## Requirements
- R1: Fetches step x from 0 to 319 within a line, then y from 0 to 239, then wrap to (0,0) and repeat without a gap in the sequence.
- R2: The fetch address is front_base + ((y << 10) | (x << 1)); with front_base 0x08000000, pixel (0,1) reads 0x08000400 and pixel (319,239) reads 0x0803BE7E.
- R3: Every fetched word appears on pix_data exactly once, in fetch order, and pix_data and pix_sof hold steady while pix_valid is high and pix_ready is low.
- R4: pix_sof is high exactly when the pixel offered is pixel (0,0) of a frame.
- R5: Register select 0 reads the front base, and a write to it requests a swap with the write data ignored. Select 1 reads and writes the back base. Select 2 reads the swap-pending flag in bit 0 with all other bits zero. Select 3 reads zero.
- R6: The front base changes only in the cycle whose fetch of pixel (319,239) is accepted, and only if a swap is pending or being requested in that cycle. The front base then takes the old back base, the back base takes the old front base (a back-base write in that same cycle wins), and the next fetch uses the new front base.
- R7: The swap-pending flag is set by a swap request and cleared by the exchange of R6.
- R8: After reset both bases read 0x08000000, no swap is pending, no fetch is requested in the first cycle, and pix_valid is low.
- R9: mem_req stays high with mem_addr unchanged until mem_ready accepts it.
- R10: Fetches in flight plus buffered pixels never exceed FIFO_DEPTH, so a returning word (mem_rvalid, at least one cycle after acceptance, in order) always finds room.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_req | output | 1 | Fetch request valid |
| mem_addr | output | ADDR_W | Fetch byte address |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rvalid | input | 1 | Returned word valid, in request order |
| mem_rdata | input | PIX_W | Returned pixel word |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | ADDR_W | Register write data |
| reg_rdata | output | ADDR_W | Register read data for reg_addr |
| pix_valid | output | 1 | Output pixel valid |
| pix_ready | input | 1 | Downstream accepts the pixel |
| pix_data | output | PIX_W | Output pixel |
| pix_sof | output | 1 | Output pixel is the first of a frame |

## Verification
The hardest case to reach from the ports is the frame boundary with a swap pending. It is visible only after a full 76,800-pixel frame has been fetched, and only while the stream is still draining pixels of the old frame. The stimulus programs a new back base, requests a swap early in the first frame and confirms the front base has not moved. It then lets the frame run at full rate so that the first fetch of the next frame appears within the cycle budget. During the opening few thousand cycles mem_ready, pix_ready and the read latency vary at random, which drives the credit limit and the output holds. A pixel deep in the first frame is rewritten in memory after the scan has started, to show that late writes are picked up.

// File: rtl/pix_scan_pkg.sv
// Shared definitions for the pixel scan controller.
// Assumes a 2-bit register select on the control port.
package pix_scan_pkg;

    // Register selects on the control port.
    typedef enum logic [1:0] {
        SREG_FRONT  = 2'd0,
        SREG_BACK   = 2'd1,
        SREG_STATUS = 2'd2,
        SREG_NONE   = 2'd3
    } scan_reg_e;

    // Bit of the status word that holds the swap-pending flag.
    localparam int STATUS_PEND_BIT = 0;

endpackage

// File: rtl/pix_raster_ctr.sv
// Raster position counter: x runs 0..H-1 inside a line, y runs 0..V-1
// across lines, and both wrap to zero after the last pixel.
// Assumes XW/YW are wide enough to hold H-1 and V-1.
module pix_raster_ctr #(
    parameter int H  = 320,
    parameter int V  = 240,
    parameter int XW = 9,
    parameter int YW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    output logic [XW-1:0] pos_x,
    output logic [YW-1:0] pos_y
);

    localparam logic [XW-1:0] X_LAST = XW'(H - 1);
    localparam logic [YW-1:0] Y_LAST = YW'(V - 1);

    // Advance one pixel in raster order on each step.
    always_ff @(posedge clk) begin : p_advance
        if (!rst_n) begin
            pos_x <= '0;
            pos_y <= '0;
        end else if (step) begin
            if (pos_x == X_LAST) begin
                pos_x <= '0;
                pos_y <= (pos_y == Y_LAST) ? '0 : pos_y + 1'b1;
            end else begin
                pos_x <= pos_x + 1'b1;
            end
        end
    end

endmodule

// File: rtl/pix_buf_regs.sv
// Front/back base registers and the deferred swap request.
// A swap request stays pending until frame_wrap, when the bases trade.
// Assumes frame_wrap pulses once per frame, on the accepted last fetch.
module pix_buf_regs
    import pix_scan_pkg::*;
#(
    parameter int               ADDR_W     = 32,
    parameter logic [ADDR_W-1:0] BASE_RESET = ADDR_W'(32'h0800_0000)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  scan_reg_e         sel,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              frame_wrap,
    output logic [ADDR_W-1:0] front_base,
    output logic [ADDR_W-1:0] back_base,
    output logic              swap_pending,
    output logic [ADDR_W-1:0] rd_data
);

    logic swap_req;
    logic back_wr;
    logic do_swap;

    // Decode the write strobe and the boundary exchange.
    always_comb begin : p_decode
        swap_req = wr_en && (sel == SREG_FRONT);
        back_wr  = wr_en && (sel == SREG_BACK);
        do_swap  = frame_wrap && (swap_pending || swap_req);
    end

    // Hold the bases and the pending flag; exchange at the frame boundary.
    always_ff @(posedge clk) begin : p_bases
        if (!rst_n) begin
            front_base   <= BASE_RESET;
            back_base    <= BASE_RESET;
            swap_pending <= 1'b0;
        end else begin
            if (do_swap) begin
                front_base <= back_base;
            end
            if (back_wr) begin
                back_base <= wr_data;
            end else if (do_swap) begin
                back_base <= front_base;
            end
            swap_pending <= do_swap ? 1'b0 : (swap_pending || swap_req);
        end
    end

    // Read mux for the control port.
    always_comb begin : p_read
        rd_data = '0;
        unique case (sel)
            SREG_FRONT:  rd_data = front_base;
            SREG_BACK:   rd_data = back_base;
            SREG_STATUS: rd_data[STATUS_PEND_BIT] = swap_pending;
            default:     rd_data = '0;
        endcase
    end

endmodule

// File: rtl/pix_resp_fifo.sv
// Small synchronous FIFO that buffers returned pixel words.
// Assumes the caller never pushes when full nor pops when empty.
module pix_resp_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 4,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     push_data,
    input  logic             pop,
    output logic [W-1:0]     pop_data,
    output logic [CNT_W-1:0] count
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

    logic [W-1:0]     slot_q [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;

    // Step a pointer with wrap at DEPTH-1.
    function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] p);
        return (p == PTR_LAST) ? '0 : p + 1'b1;
    endfunction

    // Store the incoming word.
    always_ff @(posedge clk) begin : p_store
        if (push) begin
            slot_q[wr_ptr] <= push_data;
        end
    end

    // Move pointers and occupancy.
    always_ff @(posedge clk) begin : p_ptrs
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= next_ptr(wr_ptr);
            if (pop)  rd_ptr <= next_ptr(rd_ptr);
            unique case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign pop_data = slot_q[rd_ptr];

endmodule

// File: rtl/pix_scan_ctrl.sv
// Double-buffered pixel scan controller (top).
// Fetches a frame in raster order from front_base + ((y<<Y_SHIFT)|(x<<X_SHIFT)),
// prefetching under a credit limit of FIFO_DEPTH, and streams pixels out with
// a start-of-frame flag. Assumes memory returns words in request order, at
// least one cycle after acceptance.
module pix_scan_ctrl
    import pix_scan_pkg::*;
#(
    parameter int               H_PIXELS   = 320,
    parameter int               V_LINES    = 240,
    parameter int               PIX_W      = 16,
    parameter int               ADDR_W     = 32,
    parameter int               X_SHIFT    = 1,
    parameter int               Y_SHIFT    = 10,
    parameter int               FIFO_DEPTH = 4,
    parameter logic [ADDR_W-1:0] BASE_RESET = ADDR_W'(32'h0800_0000)
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ready,
    input  logic              mem_rvalid,
    input  logic [PIX_W-1:0]  mem_rdata,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    output logic              pix_valid,
    input  logic              pix_ready,
    output logic [PIX_W-1:0]  pix_data,
    output logic              pix_sof
);

    localparam int XW    = (H_PIXELS > 1) ? $clog2(H_PIXELS) : 1;
    localparam int YW    = (V_LINES > 1) ? $clog2(V_LINES) : 1;
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
    localparam logic [XW-1:0] X_LAST = XW'(H_PIXELS - 1);
    localparam logic [YW-1:0] Y_LAST = YW'(V_LINES - 1);
    localparam logic [CNT_W:0] CREDITS = (CNT_W + 1)'(FIFO_DEPTH);

    logic              active_q;
    logic [XW-1:0]     rd_x;
    logic [YW-1:0]     rd_y;
    logic [XW-1:0]     out_x;
    logic [YW-1:0]     out_y;
    logic [CNT_W-1:0]  inflight_q;
    logic [CNT_W-1:0]  fifo_cnt;
    logic [CNT_W:0]    credit_used;
    logic              credit_ok;
    logic              issue;
    logic              rd_last;
    logic              frame_wrap;
    logic              pop;
    logic [ADDR_W-1:0] front_base;
    logic [ADDR_W-1:0] back_base;
    logic              swap_pending;
    logic [ADDR_W-1:0] y_part;
    logic [ADDR_W-1:0] x_part;

    // Let one clean cycle pass after reset before the first fetch.
    always_ff @(posedge clk) begin : p_active
        if (!rst_n) active_q <= 1'b0;
        else        active_q <= 1'b1;
    end

    // Credit check: fetches in flight plus buffered words must stay below depth.
    always_comb begin : p_credit
        credit_used = {1'b0, inflight_q} + {1'b0, fifo_cnt};
        credit_ok   = credit_used < CREDITS;
        mem_req     = active_q && credit_ok;
        issue       = mem_req && mem_ready;
        rd_last     = (rd_x == X_LAST) && (rd_y == Y_LAST);
        frame_wrap  = issue && rd_last;
    end

    // Count fetches accepted but not yet returned.
    always_ff @(posedge clk) begin : p_inflight
        if (!rst_n) begin
            inflight_q <= '0;
        end else begin
            unique case ({issue, mem_rvalid})
                2'b10:   inflight_q <= inflight_q + 1'b1;
                2'b01:   inflight_q <= inflight_q - 1'b1;
                default: inflight_q <= inflight_q;
            endcase
        end
    end

    // Pack the coordinates into a byte offset and add the front base.
    always_comb begin : p_addr
        y_part   = ADDR_W'(rd_y) << Y_SHIFT;
        x_part   = ADDR_W'(rd_x) << X_SHIFT;
        mem_addr = front_base + (y_part | x_part);
    end

    // Fetch-side raster position.
    pix_raster_ctr #(
        .H (H_PIXELS), .V (V_LINES), .XW (XW), .YW (YW)
    ) u_rd_pos (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (issue),
        .pos_x (rd_x),
        .pos_y (rd_y)
    );

    // Base registers and swap control.
    pix_buf_regs #(
        .ADDR_W (ADDR_W), .BASE_RESET (BASE_RESET)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (reg_wr),
        .sel          (scan_reg_e'(reg_addr)),
        .wr_data      (reg_wdata),
        .frame_wrap   (frame_wrap),
        .front_base   (front_base),
        .back_base    (back_base),
        .swap_pending (swap_pending),
        .rd_data      (reg_rdata)
    );

    // Response buffer between memory and the pixel stream.
    pix_resp_fifo #(
        .W (PIX_W), .DEPTH (FIFO_DEPTH), .CNT_W (CNT_W)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (mem_rvalid),
        .push_data (mem_rdata),
        .pop       (pop),
        .pop_data  (pix_data),
        .count     (fifo_cnt)
    );

    // Output handshake.
    always_comb begin : p_out
        pix_valid = (fifo_cnt != '0);
        pop       = pix_valid && pix_ready;
        pix_sof   = pix_valid && (out_x == '0) && (out_y == '0);
    end

    // Output-side raster position, used for the frame-start flag.
    pix_raster_ctr #(
        .H (H_PIXELS), .V (V_LINES), .XW (XW), .YW (YW)
    ) u_out_pos (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (pop),
        .pos_x (out_x),
        .pos_y (out_y)
    );

endmodule

// File: rtl/pix_scan_ctrl_chk.sv
// Protocol and state checker for pix_scan_ctrl, attached with bind.
module pix_scan_ctrl_chk #(
    parameter int ADDR_W     = 32,
    parameter int PIX_W      = 16,
    parameter int CNT_W      = 3,
    parameter int FIFO_DEPTH = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_rvalid,
    input logic              pix_valid,
    input logic              pix_ready,
    input logic [PIX_W-1:0]  pix_data,
    input logic              pix_sof,
    input logic [CNT_W-1:0]  fifo_cnt,
    input logic [ADDR_W-1:0] front_base,
    input logic [ADDR_W-1:0] back_base,
    input logic              swap_pending,
    input logic              frame_wrap
);

    assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr));

    assert_out_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid && !pix_ready |=> pix_valid && $stable(pix_data) && $stable(pix_sof));

    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rvalid |-> fifo_cnt < CNT_W'(FIFO_DEPTH));

    assert_front_at_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(front_base) |-> $past(frame_wrap));

    assert_pend_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(swap_pending) |-> $past(frame_wrap) && front_base == $past(back_base));

    assert_single_sof_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid && pix_ready && pix_sof |=> !pix_sof);

endmodule

bind pix_scan_ctrl pix_scan_ctrl_chk #(
    .ADDR_W (ADDR_W), .PIX_W (PIX_W), .CNT_W (CNT_W), .FIFO_DEPTH (FIFO_DEPTH)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mem_req      (mem_req),
    .mem_ready    (mem_ready),
    .mem_addr     (mem_addr),
    .mem_rvalid   (mem_rvalid),
    .pix_valid    (pix_valid),
    .pix_ready    (pix_ready),
    .pix_data     (pix_data),
    .pix_sof      (pix_sof),
    .fifo_cnt     (fifo_cnt),
    .front_base   (front_base),
    .back_base    (back_base),
    .swap_pending (swap_pending),
    .frame_wrap   (frame_wrap)
);

// File: tb/pix_scan_ctrl_bench.sv
// Cycle-level reference model bench for pix_scan_ctrl.
module pix_scan_ctrl_bench;

    localparam int H = 320;
    localparam int V = 240;
    localparam int DEPTH = 4;
    localparam logic [31:0] BASE0 = 32'h0800_0000;
    localparam logic [31:0] BASE1 = 32'h0900_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ready = 1'b0;
    logic        mem_rvalid = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        pix_valid;
    logic        pix_ready = 1'b0;
    logic [15:0] pix_data;
    logic        pix_sof;

    always #5 clk = ~clk;

    pix_scan_ctrl u_pix_scan_ctrl (
        .clk (clk), .rst_n (rst_n),
        .mem_req (mem_req), .mem_addr (mem_addr), .mem_ready (mem_ready),
        .mem_rvalid (mem_rvalid), .mem_rdata (mem_rdata),
        .reg_wr (reg_wr), .reg_addr (reg_addr), .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pix_valid (pix_valid), .pix_ready (pix_ready),
        .pix_data (pix_data), .pix_sof (pix_sof)
    );

    typedef struct { int due; logic [15:0] data; } resp_t;

    resp_t       resp_q[$];
    logic [15:0] exp_q[$];
    logic [15:0] overlay[int];
    int          checks = 0, errors = 0, cyc = 0, lat = 2;
    int          mx = 0, my = 0, ox = 0, oy = 0;
    int          fr_iss = 0, fr_out = 0, dut_sof = 0;
    logic [31:0] front = BASE0, back = BASE0;
    bit          pend = 0, active = 0, done = 0;
    logic [1:0]  rsel_q = 2'd0;

    function automatic logic [15:0] mem_word(input logic [31:0] a);
        if (overlay.exists(int'(a))) return overlay[int'(a)];
        return a[16:1] ^ a[31:16];
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Compare, drive, then advance the model to the state after the next edge.
    always @(negedge clk) begin
        bit iss, popd, swr, bwr, last, doswap;
        logic [31:0] a, rexp, nf, nb;
        cyc++;
        if (!done && cyc >= 2) begin
            // Per-cycle comparison against the model.
            chk("R8/R9 mem_req", mem_req, active && (resp_q.size() + exp_q.size() < DEPTH));
            if (mem_req)
                chk("R1/R2 mem_addr", mem_addr, front + ((my << 10) | (mx << 1)));
            chk("R3 pix_valid", pix_valid, exp_q.size() > 0);
            if (pix_valid) begin
                chk("R3 pix_data", pix_data, exp_q[0]);
                chk("R4 pix_sof", pix_sof, ox == 0 && oy == 0);
            end
            case (rsel_q)
                2'd0: rexp = front;
                2'd1: rexp = back;
                2'd2: rexp = {31'd0, pend};
                default: rexp = '0;
            endcase
            chk("R5 reg_rdata", reg_rdata, rexp);
            if (cyc == 2) begin
                chk("R8 reset mem_req", mem_req, 0);
                chk("R8 reset pix_valid", pix_valid, 0);
                chk("R8 reset base", reg_rdata, BASE0);
            end
            if (cyc == 200) chk("R6 front unchanged mid-frame", reg_rdata, BASE0);
            if (cyc == 201) chk("R7 swap pending", reg_rdata, 32'd1);
        end

        // Drive inputs for the next edge.
        rst_n     = (cyc >= 3);
        mem_ready = (cyc < 3000) ? ($urandom % 2 == 1) : 1'b1;
        pix_ready = (cyc < 3000) ? ($urandom % 3 != 0) : 1'b1;
        lat       = (cyc < 3000) ? 1 + ($urandom % 4) : 2;
        reg_wr    = 1'b0;
        reg_addr  = 2'(cyc % 4);
        reg_wdata = 32'hDEAD_BEEF;
        if (cyc == 10) begin reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = BASE1; end
        if (cyc == 20) begin reg_wr = 1'b1; reg_addr = 2'd0; end
        if (cyc == 25) overlay[int'(BASE0 + ((100 << 10) | (5 << 1)))] = 16'hBEEF;
        if (cyc == 199) reg_addr = 2'd0;
        if (cyc == 200) reg_addr = 2'd2;
        mem_rvalid = resp_q.size() > 0 && resp_q[0].due <= cyc;
        mem_rdata  = mem_rvalid ? resp_q[0].data : 16'h0;
        rsel_q     = reg_addr;

        // Model update for the coming edge.
        if (!rst_n) begin
            resp_q.delete(); exp_q.delete();
            mx = 0; my = 0; ox = 0; oy = 0;
            front = BASE0; back = BASE0; pend = 0; active = 0;
        end else if (!done) begin
            iss  = active && (resp_q.size() + exp_q.size() < DEPTH) && mem_ready;
            popd = exp_q.size() > 0 && pix_ready;
            swr  = reg_wr && reg_addr == 2'd0;
            bwr  = reg_wr && reg_addr == 2'd1;
            last = 0;
            if (popd) begin
                if (pix_sof) dut_sof++;
                if (ox == 5 && oy == 100 && fr_out == 0)
                    chk("R3 late memory write seen", pix_data, 16'hBEEF);
                void'(exp_q.pop_front());
                if (ox == H - 1) begin
                    ox = 0;
                    if (oy == V - 1) begin oy = 0; fr_out++; end else oy++;
                end else ox++;
            end
            if (mem_rvalid) exp_q.push_back(resp_q.pop_front().data);
            if (iss) begin
                a = front + ((my << 10) | (mx << 1));
                if (fr_iss == 0 && mx == 0 && my == 1) chk("R2 pixel (0,1)", mem_addr, 32'h0800_0400);
                if (fr_iss == 0 && mx == H - 1 && my == V - 1) chk("R2 pixel (319,239)", mem_addr, 32'h0803_BE7E);
                if (fr_iss == 1 && mx == 0 && my == 0) chk("R6 new front used", mem_addr, BASE1);
                resp_q.push_back('{cyc + lat, mem_word(a)});
                last = (mx == H - 1 && my == V - 1);
                if (mx == H - 1) begin
                    mx = 0;
                    if (my == V - 1) begin my = 0; fr_iss++; end else my++;
                end else mx++;
            end
            doswap = last && (pend || swr);
            nf   = doswap ? back : front;
            nb   = bwr ? reg_wdata : (doswap ? front : back);
            pend = doswap ? 1'b0 : (pend || swr);
            front = nf; back = nb;
            active = 1;
            if (fr_out == 1 && oy == 4) begin
                chk("R4 frame starts seen", dut_sof, 2);
                chk("R7 pending cleared", pend, 0);
                chk("R6 bases exchanged", back, BASE0);
                done = 1;
            end
        end
        if (!done && cyc > 150000) begin
            checks++; errors++;
            $display("FAIL watchdog R3 actual=%0d expected=%0d pixels", fr_out, 1);
            done = 1;
        end
    end

    initial begin
        wait (done);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule